// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two byte-wide buses, A and B, and can forward data in either direction. A direction can forward either the live value currently on the opposite bus or a copy of that bus held in a capture register. Each bus has its own capture register and its own capture strobe. A capture happens on every rising edge of that bus's strobe, whatever the driving state is. An active-low output enable and a direction input decide which bus is driven, if either. Two select inputs pick live or stored data, one select per direction.

The capture strobes are ordinary inputs sampled in the system clock domain. A rising edge is found by comparing a strobe with its value on the previous clock. Tri-state pins are modelled as a data-in vector, a data-out vector and a one-bit drive enable for each bus. A data-out vector reads zero whenever its drive enable is low. A parameter builds an inverting variant in which every bit that crosses between the buses is complemented, on the live path and on the stored path alike.

The buses carry plain levels with no handshake. This point of the house style does not fit the block, so no valid/ready interface is used and no back-pressure rules apply.

Top module: `regbus_xcvr`

## Requirements
- R1: When `cap_a_stb` is low on one clock edge and high on the next, register A loads `a_in` at that next edge. The new value is visible on a stored-mode read from the following cycle.
- R2: When `cap_b_stb` is low on one clock edge and high on the next, register B loads `b_in` at that next edge. The new value is visible on a stored-mode read from the following cycle.
- R3: Captures take place under every setting of `oe_n` and `dir`, including isolation. A strobe held high past its rising edge causes no further capture.
- R4: While `oe_n` is 1, `a_drv` and `b_drv` are both 0.
- R5: While `oe_n` is 0 and `dir` is 1, `b_drv` is 1 and `a_drv` is 0.
- R6: While `oe_n` is 0 and `dir` is 0, `a_drv` is 1 and `b_drv` is 0.
- R7: While B is driven, `sel_a2b` = 0 puts the live `a_in` on `b_out`, and `sel_a2b` = 1 puts register A on `b_out`.
- R8: While A is driven, `sel_b2a` = 0 puts the live `b_in` on `a_out`, and `sel_b2a` = 1 puts register B on `a_out`.
- R9: With `INVERT` = 1, every bit of the driven output is the complement of the selected source, on both the live path and the stored path.
- R10: An output vector whose drive enable is 0 reads all zeros.
- R11: A synchronous active-high `rst` clears both registers at the clock edge. The drive enables follow only `oe_n` and `dir`, including while reset is active.
- R12: If a capture edge and a stored-mode read of the same register fall in the same cycle, the output shows the value held before that edge. The newly captured value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive B from A side; 0: drive A from B side |
| sel_a2b | input | 1 | Source for B: 0 live A, 1 register A |
| sel_b2a | input | 1 | Source for A: 0 live B, 1 register B |
| cap_a_stb | input | 1 | Capture strobe for register A (rising edge) |
| cap_b_stb | input | 1 | Capture strobe for register B (rising edge) |
| a_in | input | WIDTH | Value sensed on bus A |
| a_out | output | WIDTH | Value driven onto bus A |
| a_drv | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value sensed on bus B |
| b_out | output | WIDTH | Value driven onto bus B |
| b_drv | output | 1 | Drive enable for bus B |

## Verification
Two functions can fall in the same cycle: a capture strobe edge and a stored-mode read of the same register. The bench makes the strobe rise while the output is being read in stored mode and gives `a_in` a new value in that cycle. The output must show the old register contents before the clock edge and the new value after it. A second overlap, a capture during isolation, is judged afterwards by switching to stored mode and reading the captured value on the driven bus.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic [1:0] {
    DRIVE_NONE  = 2'b00,
    DRIVE_BUS_A = 2'b01,
    DRIVE_BUS_B = 2'b10
  } drive_mode_e;

  function automatic drive_mode_e decode_drive(input logic oe_n, input logic dir);
    if (oe_n)     return DRIVE_NONE;
    else if (dir) return DRIVE_BUS_B;
    else          return DRIVE_BUS_A;
  endfunction

endpackage

// File: rtl/rbx_strobe_edge.sv
module rbx_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  // During reset the history tracks the strobe, so a level held through reset is no edge.
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q & ~rst;

endmodule

// File: rtl/rbx_cap_reg.sv
module rbx_cap_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= d;
  end

  // R1 / R2: a detected edge loads the bus value seen in that cycle
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    capture |=> (q == $past(d)));

  // R3: without an edge the register holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(q));

endmodule

// File: rtl/rbx_dir_ctrl.sv
module rbx_dir_ctrl
  import regbus_pkg::*;
(
  input  logic clk,
  input  logic oe_n,
  input  logic dir,
  output logic a_drv,
  output logic b_drv
);
  drive_mode_e mode;

  assign mode  = decode_drive(oe_n, dir);
  assign a_drv = (mode == DRIVE_BUS_A);
  assign b_drv = (mode == DRIVE_BUS_B);

  // R5 / R6: never both buses driven
  p_one_side_r5: assert property (@(posedge clk) !(a_drv && b_drv));

endmodule

// File: rtl/rbx_port_drive.sv
module rbx_port_drive #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             use_stored,
  input  logic             drive,
  output logic [WIDTH-1:0] out
);
  logic [WIDTH-1:0] src;

  assign src = use_stored ? stored : live;

  generate
    if (INVERT) begin : g_inv
      assign out = drive ? ~src : '0;
    end else begin : g_true
      assign out = drive ? src : '0;
    end
  endgenerate

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic             cap_a_stb,
  input  logic             cap_b_stb,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv
);
  logic             rise_a, rise_b;
  logic [WIDTH-1:0] held_a, held_b;

  rbx_strobe_edge u_edge_a (.clk(clk), .rst(rst), .strobe(cap_a_stb), .rise(rise_a));
  rbx_strobe_edge u_edge_b (.clk(clk), .rst(rst), .strobe(cap_b_stb), .rise(rise_b));

  rbx_cap_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk(clk), .rst(rst), .capture(rise_a), .d(a_in), .q(held_a));
  rbx_cap_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk(clk), .rst(rst), .capture(rise_b), .d(b_in), .q(held_b));

  rbx_dir_ctrl u_dir (.clk(clk), .oe_n(oe_n), .dir(dir), .a_drv(a_drv), .b_drv(b_drv));

  rbx_port_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
    .live(a_in), .stored(held_a), .use_stored(sel_a2b), .drive(b_drv), .out(b_out));
  rbx_port_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
    .live(b_in), .stored(held_b), .use_stored(sel_b2a), .drive(a_drv), .out(a_out));

  // R4: isolation drives neither bus
  p_isolate_r4: assert property (@(posedge clk) oe_n |-> (!a_drv && !b_drv));

  // R10: an undriven bus presents zeros
  p_quiet_a_r10: assert property (@(posedge clk) !a_drv |-> (a_out == '0));
  p_quiet_b_r10: assert property (@(posedge clk) !b_drv |-> (b_out == '0));

  // R11: reset empties both registers
  p_reset_r11: assert property (@(posedge clk) rst |=> (held_a == '0 && held_b == '0));

endmodule

// File: tb/tb_regbus_xcvr.sv
module tb_regbus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_n = 1'b1, dir = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic cap_a_stb = 1'b0, cap_b_stb = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, ai_out, bi_out;
  logic a_drv, b_drv, ai_drv, bi_drv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .cap_a_stb(cap_a_stb), .cap_b_stb(cap_b_stb), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv));

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .cap_a_stb(cap_a_stb), .cap_b_stb(cap_b_stb), .a_in(a_in), .a_out(ai_out), .a_drv(ai_drv),
    .b_in(b_in), .b_out(bi_out), .b_drv(bi_drv));

  // {oe_n, dir, sel_a2b, sel_b2a, a_in, b_in, exp a_drv, exp b_drv, exp a_out, exp b_out}
  // Registers preloaded: A = 8'h5A, B = 8'hC3.
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {4'b1111, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},  // R4 R10 isolation
    {4'b0100, 8'h11, 8'h22, 2'b01, 8'h00, 8'h11},  // R5 R7 live A->B
    {4'b0110, 8'h11, 8'h22, 2'b01, 8'h00, 8'h5A},  // R7 stored A->B
    {4'b0000, 8'h11, 8'h22, 2'b10, 8'h22, 8'h00},  // R6 R8 live B->A
    {4'b0001, 8'h11, 8'h22, 2'b10, 8'hC3, 8'h00},  // R8 stored B->A
    {4'b1000, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},  // R4 isolation, other dir
    {4'b0100, 8'hF0, 8'h22, 2'b01, 8'h00, 8'hF0},  // R7 live pattern
    {4'b0000, 8'h11, 8'h0F, 2'b10, 8'h0F, 8'h00}   // R8 live pattern
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_a(input logic [W-1:0] v);
    a_in = v; cap_a_stb = 1'b1; tick(); cap_a_stb = 1'b0; tick();
  endtask

  task automatic load_b(input logic [W-1:0] v);
    b_in = v; cap_b_stb = 1'b1; tick(); cap_b_stb = 1'b0; tick();
  endtask

  task automatic set_ctl(input logic o, input logic d, input logic sab, input logic sba);
    oe_n = o; dir = d; sel_a2b = sab; sel_b2a = sba; #1;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R11: drive enables follow oe_n/dir during reset; registers cleared
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R11 b_drv in reset", {31'd0, b_drv}, 32'd1);
    rst = 1'b0; tick();
    chk("R11 reg A after reset", {24'd0, b_out}, 32'h00);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 reg B after reset", {24'd0, a_out}, 32'h00);

    // Preload in isolation: R3, R1, R2
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    load_a(8'h5A);
    load_b(8'hC3);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 R3 capture A in isolation", {24'd0, b_out}, 32'h5A);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 R3 capture B in isolation", {24'd0, a_out}, 32'hC3);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      a_in = v[33:26]; b_in = v[25:18];
      set_ctl(v[37], v[36], v[35], v[34]);
      chk($sformatf("R4-8 vec%0d a_drv", i), {31'd0, a_drv}, {31'd0, v[17]});
      chk($sformatf("R5 R6 vec%0d b_drv", i), {31'd0, b_drv}, {31'd0, v[16]});
      chk($sformatf("R8 R10 vec%0d a_out", i), {24'd0, a_out}, {24'd0, v[15:8]});
      chk($sformatf("R7 R10 vec%0d b_out", i), {24'd0, b_out}, {24'd0, v[7:0]});
      tick();
    end

    // R9: inverting variant on both paths
    a_in = 8'h11; b_in = 8'h22;
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 inverted live A->B", {24'd0, bi_out}, 32'hEE);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 inverted stored A->B", {24'd0, bi_out}, 32'hA5);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 inverted stored B->A", {24'd0, ai_out}, 32'h3C);
    set_ctl(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9 R10 inverted undriven", {24'd0, ai_out}, 32'h00);

    // R12: edge and stored read in the same cycle
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    a_in = 8'h77; cap_a_stb = 1'b1; #1;
    chk("R12 old value during edge cycle", {24'd0, b_out}, 32'h5A);
    tick();
    chk("R12 new value after edge", {24'd0, b_out}, 32'h77);

    // R3: strobe held high does not capture again
    a_in = 8'h99; tick(); tick();
    chk("R3 level does not recapture", {24'd0, b_out}, 32'h77);
    cap_a_stb = 1'b0; tick();

    // R2 with bus A driven: B register captures while A is output
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    load_b(8'h3E);
    chk("R2 R3 capture B while A driven", {24'd0, a_out}, 32'h3E);

    // R11: reset mid-run clears loaded registers
    rst = 1'b1; tick(); rst = 1'b0; #1;
    chk("R11 reg B cleared", {24'd0, a_out}, 32'h00);
    chk("R11 a_drv unaffected", {31'd0, a_drv}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule